// File: doc/BRIEF.md
# Renamed Floating-Point Register File

This block holds the architectural floating-point registers of an out-of-order core, together with a rename record for each one. Each register has a data word, a pending flag and a producer tag. The producer tag names the in-flight instruction that will deliver the register's next value. Tag value 0 is reserved and means that no producer is pending.

At issue, the two source ports look up operands. A source whose register has no pending producer comes back with its data. A source whose register is still waiting comes back with the producer's tag, and the reservation station then watches the result bus for that tag. The destination port records the issuing instruction as the newest producer of its target register.

The block snoops the result bus. A register accepts a broadcast only when the broadcast tag equals its own producer tag. As a result, an older producer's result is dropped once a younger instruction has renamed the same register. Reservation stations, queues and decode logic are outside the block.

Top module: `rtf_regfile`

## Requirements
- R1: After a synchronous reset every register has no pending producer and holds the value 0. A read of any register then returns ready=1, value 0 and tag 0.
- R2: A read of a register with no pending producer returns, one clock after the address is sampled, ready=1, the stored value and tag 0.
- R3: A read of a register with a pending producer returns, one clock later, ready=0, value 0 and the producer's tag.
- R4: A rename with a nonzero tag marks the addressed register pending and records that tag as its producer.
- R5: A result broadcast whose nonzero tag equals a pending register's producer tag writes the broadcast value into that register and clears its pending flag.
- R6: A broadcast whose tag differs from a register's current producer tag leaves that register's value, pending flag and tag unchanged. This holds when the tag belongs to an older producer that was renamed over.
- R7: When a rename and a matching broadcast hit the same register in one cycle, the rename wins: the register stays pending with the new tag.
- R8: A read in the same cycle as a broadcast that matches the read register's producer returns ready=1 with the broadcast value.
- R9: A read in the same cycle as a rename of the same register returns the register's state from before that rename.
- R10: A rename carrying tag 0 has no effect, and a broadcast carrying tag 0 updates no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_addr | input | 4 | Source port 0 register index |
| rd0_ready | output | 1 | Port 0 operand is a value (registered) |
| rd0_value | output | 32 | Port 0 operand value, 0 when pending |
| rd0_tag | output | 4 | Port 0 producer tag, 0 when ready |
| rd1_addr | input | 4 | Source port 1 register index |
| rd1_ready | output | 1 | Port 1 operand is a value (registered) |
| rd1_value | output | 32 | Port 1 operand value, 0 when pending |
| rd1_tag | output | 4 | Port 1 producer tag, 0 when ready |
| ren_valid | input | 1 | Destination rename request |
| ren_addr | input | 4 | Register being renamed |
| ren_tag | input | 4 | Tag of the issuing instruction |
| res_valid | input | 1 | Result bus broadcast valid |
| res_tag | input | 4 | Tag of the completing instruction |
| res_value | input | 32 | Broadcast result value |

## Verification
The embedded assertions check four rules on every cycle:
- a rename leaves its register pending with the new tag;
- a matching broadcast stores its value and releases the register unless a rename collides with it;
- a non-matching broadcast leaves every register's data alone;
- the read outputs always present a tag exactly when they are not ready.

The orderings that depend on a sequence of events can only be shown by the bench's scenarios: a stale result arriving after a second rename, a same-cycle collision of rename and broadcast, and the bypass of a broadcast into a concurrent read. The bench compares each read against a reference model that it updates independently.

// File: rtl/rtf_pkg.sv
package rtf_pkg;
  localparam int NUM_REGS   = 16;
  localparam int DATA_W     = 32;
  localparam int TAG_W      = 4;
  localparam int IDX_W      = $clog2(NUM_REGS);
endpackage

// File: rtl/rtf_tag_state.sv
module rtf_tag_state #(
  parameter int NREG = rtf_pkg::NUM_REGS,
  parameter int TW   = rtf_pkg::TAG_W,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ren_valid,
  input  logic [AW-1:0]            ren_addr,
  input  logic [TW-1:0]            ren_tag,
  input  logic                     res_valid,
  input  logic [TW-1:0]            res_tag,
  output logic [NREG-1:0]          pend_q,
  output logic [NREG-1:0][TW-1:0]  tag_q,
  output logic [NREG-1:0]          hit_o
);
  logic ren_live;
  logic res_live;
  assign ren_live = ren_valid && (ren_tag != '0);
  assign res_live = res_valid && (res_tag != '0);

  for (genvar i = 0; i < NREG; i++) begin : g_entry
    logic take;
    assign hit_o[i] = res_live && pend_q[i] && (tag_q[i] == res_tag);
    assign take     = ren_live && (ren_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        tag_q[i]  <= '0;
      end else if (take) begin
        pend_q[i] <= 1'b1;
        tag_q[i]  <= ren_tag;
      end else if (hit_o[i]) begin
        pend_q[i] <= 1'b0;
        tag_q[i]  <= '0;
      end
    end

    AST_COLLIDE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
      (take && hit_o[i]) |=> (pend_q[i] && tag_q[i] == $past(ren_tag))); // R7
  end

  AST_RENAME_RECORDED: assert property (@(posedge clk) disable iff (rst)
    ren_live |=> (pend_q[$past(ren_addr)] && tag_q[$past(ren_addr)] == $past(ren_tag))); // R4
endmodule

// File: rtl/rtf_value_store.sv
module rtf_value_store #(
  parameter int NREG = rtf_pkg::NUM_REGS,
  parameter int DW   = rtf_pkg::DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NREG-1:0]          wr_en,
  input  logic [DW-1:0]            wr_data,
  output logic [NREG-1:0][DW-1:0]  val_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        val_q[i] <= '0;
      else if (wr_en[i])
        val_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/rtf_read_port.sv
module rtf_read_port #(
  parameter int NREG = rtf_pkg::NUM_REGS,
  parameter int DW   = rtf_pkg::DATA_W,
  parameter int TW   = rtf_pkg::TAG_W,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0]          pend,
  input  logic [NREG-1:0][TW-1:0]  tags,
  input  logic [NREG-1:0][DW-1:0]  vals,
  input  logic                     res_valid,
  input  logic [TW-1:0]            res_tag,
  input  logic [DW-1:0]            res_value,
  output logic                     ready_q,
  output logic [DW-1:0]            value_q,
  output logic [TW-1:0]            tag_q
);
  logic          sel_pend;
  logic [TW-1:0] sel_tag;
  logic          bypass;

  assign sel_pend = pend[addr];
  assign sel_tag  = tags[addr];
  assign bypass   = sel_pend && res_valid && (res_tag != '0) && (res_tag == sel_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      value_q <= '0;
      tag_q   <= '0;
    end else if (bypass) begin
      ready_q <= 1'b1;
      value_q <= res_value;
      tag_q   <= '0;
    end else if (sel_pend) begin
      ready_q <= 1'b0;
      value_q <= '0;
      tag_q   <= sel_tag;
    end else begin
      ready_q <= 1'b1;
      value_q <= vals[addr];
      tag_q   <= '0;
    end
  end

  AST_PENDING_HAS_TAG: assert property (@(posedge clk) disable iff (rst)
    !ready_q |-> (tag_q != '0 && value_q == '0)); // R3
  AST_READY_NO_TAG: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (tag_q == '0)); // R2
endmodule

// File: rtl/rtf_regfile.sv
module rtf_regfile #(
  parameter int NREG = rtf_pkg::NUM_REGS,
  parameter int DW   = rtf_pkg::DATA_W,
  parameter int TW   = rtf_pkg::TAG_W,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd0_addr,
  output logic          rd0_ready,
  output logic [DW-1:0] rd0_value,
  output logic [TW-1:0] rd0_tag,
  input  logic [AW-1:0] rd1_addr,
  output logic          rd1_ready,
  output logic [DW-1:0] rd1_value,
  output logic [TW-1:0] rd1_tag,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_addr,
  input  logic [TW-1:0] ren_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_value
);
  logic [NREG-1:0]          pend;
  logic [NREG-1:0][TW-1:0]  tags;
  logic [NREG-1:0][DW-1:0]  vals;
  logic [NREG-1:0]          hit;

  rtf_tag_state #(.NREG(NREG), .TW(TW)) u_tags (
    .clk(clk), .rst(rst),
    .ren_valid(ren_valid), .ren_addr(ren_addr), .ren_tag(ren_tag),
    .res_valid(res_valid), .res_tag(res_tag),
    .pend_q(pend), .tag_q(tags), .hit_o(hit)
  );

  rtf_value_store #(.NREG(NREG), .DW(DW)) u_vals (
    .clk(clk), .rst(rst), .wr_en(hit), .wr_data(res_value), .val_q(vals)
  );

  logic [1:0][AW-1:0] rd_addr;
  logic [1:0]         rd_ready;
  logic [1:0][DW-1:0] rd_value;
  logic [1:0][TW-1:0] rd_tag;
  assign rd_addr[0] = rd0_addr;
  assign rd_addr[1] = rd1_addr;

  for (genvar p = 0; p < 2; p++) begin : g_port
    rtf_read_port #(.NREG(NREG), .DW(DW), .TW(TW)) u_rd (
      .clk(clk), .rst(rst), .addr(rd_addr[p]),
      .pend(pend), .tags(tags), .vals(vals),
      .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
      .ready_q(rd_ready[p]), .value_q(rd_value[p]), .tag_q(rd_tag[p])
    );
  end

  assign rd0_ready = rd_ready[0];
  assign rd0_value = rd_value[0];
  assign rd0_tag   = rd_tag[0];
  assign rd1_ready = rd_ready[1];
  assign rd1_value = rd_value[1];
  assign rd1_tag   = rd_tag[1];

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    AST_STALE_RESULT_DROPPED: assert property (@(posedge clk) disable iff (rst)
      (res_valid && pend[i] && tags[i] != res_tag) |=> $stable(vals[i])); // R6
    AST_MATCH_WRITES_BACK: assert property (@(posedge clk) disable iff (rst)
      (res_valid && res_tag != '0 && pend[i] && tags[i] == res_tag &&
       !(ren_valid && ren_tag != '0 && ren_addr == AW'(i)))
      |=> (!pend[i] && vals[i] == $past(res_value))); // R5
  end
endmodule

// File: tb/rtf_regfile_test.sv
`timescale 1ns/1ps
module rtf_regfile_test;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int TW   = 4;
  localparam int AW   = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] rd0_addr, rd1_addr, ren_addr;
  logic          rd0_ready, rd1_ready, ren_valid, res_valid;
  logic [DW-1:0] rd0_value, rd1_value, res_value;
  logic [TW-1:0] rd0_tag, rd1_tag, ren_tag, res_tag;

  always #5 clk = ~clk;

  rtf_regfile uut (
    .clk(clk), .rst(rst),
    .rd0_addr(rd0_addr), .rd0_ready(rd0_ready), .rd0_value(rd0_value), .rd0_tag(rd0_tag),
    .rd1_addr(rd1_addr), .rd1_ready(rd1_ready), .rd1_value(rd1_value), .rd1_tag(rd1_tag),
    .ren_valid(ren_valid), .ren_addr(ren_addr), .ren_tag(ren_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic          m_pend [NREG];
  logic [TW-1:0] m_tag  [NREG];
  logic [DW-1:0] m_val  [NREG];

  function automatic logic [DW+TW:0] predict(input logic [AW-1:0] a, input logic cv,
                                             input logic [TW-1:0] ct, input logic [DW-1:0] cd);
    if (m_pend[a] && cv && ct != 0 && m_tag[a] == ct) return {1'b1, cd, {TW{1'b0}}};
    if (m_pend[a]) return {1'b0, {DW{1'b0}}, m_tag[a]};
    return {1'b1, m_val[a], {TW{1'b0}}};
  endfunction

  function automatic string label_of(input logic [AW-1:0] a, input logic cv,
                                     input logic [TW-1:0] ct);
    if (m_pend[a] && cv && ct != 0 && m_tag[a] == ct) return "R8";
    if (m_pend[a]) return "R3";
    return "R2";
  endfunction

  task automatic advance_model(input logic rv, input logic [AW-1:0] ra, input logic [TW-1:0] rt,
                               input logic cv, input logic [TW-1:0] ct, input logic [DW-1:0] cd);
    for (int i = 0; i < NREG; i++) begin
      logic hit, take;
      hit  = cv && ct != 0 && m_pend[i] && m_tag[i] == ct;
      take = rv && rt != 0 && ra == AW'(i);
      if (hit) m_val[i] = cd;
      if (take) begin m_pend[i] = 1'b1; m_tag[i] = rt; end
      else if (hit) begin m_pend[i] = 1'b0; m_tag[i] = '0; end
    end
  endtask

  task automatic compare(input string req, input logic [DW+TW:0] got, input logic [DW+TW:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ready/value/tag actual %b/%h/%h expected %b/%h/%h", req,
               got[DW+TW], got[DW+TW-1:TW], got[TW-1:0], exp[DW+TW], exp[DW+TW-1:TW], exp[TW-1:0]);
    end
  endtask

  // One clock: drive at negedge, predict, update model, compare at next negedge.
  task automatic step(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                      input logic rv, input logic [AW-1:0] ra, input logic [TW-1:0] rt,
                      input logic cv, input logic [TW-1:0] ct, input logic [DW-1:0] cd,
                      input string tag_override);
    logic [DW+TW:0] e0, e1;
    string l0, l1;
    rd0_addr = a0; rd1_addr = a1;
    ren_valid = rv; ren_addr = ra; ren_tag = rt;
    res_valid = cv; res_tag = ct; res_value = cd;
    e0 = predict(a0, cv, ct, cd); e1 = predict(a1, cv, ct, cd);
    l0 = (tag_override != "") ? tag_override : label_of(a0, cv, ct);
    l1 = (tag_override != "") ? tag_override : label_of(a1, cv, ct);
    advance_model(rv, ra, rt, cv, ct, cd);
    @(negedge clk);
    compare(l0, {rd0_ready, rd0_value, rd0_tag}, e0);
    compare(l1, {rd1_ready, rd1_value, rd1_tag}, e1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1;
    rd0_addr = '0; rd1_addr = '0; ren_valid = 0; ren_addr = '0; ren_tag = '0;
    res_valid = 0; res_tag = '0; res_value = '0;
    for (int i = 0; i < NREG; i++) begin m_pend[i] = 0; m_tag[i] = '0; m_val[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    step(4'd0, 4'd15, 0, 0, 0, 0, 0, 0, "R1");                     // R1 reset state
    step(4'd5, 4'd9, 0, 0, 0, 0, 0, 0, "R1");
    step(4'd3, 4'd3, 1, 4'd3, 4'd5, 0, 0, 0, "R9");                // R4 rename r3 -> tag 5
    step(4'd3, 4'd0, 0, 0, 0, 0, 0, 0, "R4");                      // pending tag 5
    step(4'd3, 4'd3, 1, 4'd3, 4'd6, 0, 0, 0, "R9");                // R9 read sees tag 5
    step(4'd3, 4'd1, 0, 0, 0, 1, 4'd5, 32'hDEAD_0005, "");         // stale broadcast
    step(4'd3, 4'd3, 0, 0, 0, 0, 0, 0, "R6");                      // R6 still tag 6
    step(4'd2, 4'd2, 0, 0, 0, 1, 4'd6, 32'hCAFE_0006, "");         // R5 writeback
    step(4'd3, 4'd3, 0, 0, 0, 0, 0, 0, "R5");
    step(4'd0, 4'd0, 1, 4'd7, 4'd2, 0, 0, 0, "");
    step(4'd0, 4'd0, 1, 4'd7, 4'd4, 1, 4'd2, 32'h1111_2222, "");   // R7 collision
    step(4'd7, 4'd7, 0, 0, 0, 0, 0, 0, "R7");
    step(4'd7, 4'd3, 0, 0, 0, 1, 4'd4, 32'h3333_4444, "R8");       // R8 bypass
    step(4'd7, 4'd7, 0, 0, 0, 0, 0, 0, "R5");
    step(4'd8, 4'd8, 1, 4'd8, 4'd0, 1, 4'd0, 32'h7777_7777, "");   // R10 tag 0 ignored
    step(4'd8, 4'd8, 0, 0, 0, 0, 0, 0, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a0, a1, ra, pick;
      logic [TW-1:0] rt, ct;
      logic rv, cv;
      a0 = AW'($urandom_range(0, NREG-1));
      a1 = AW'($urandom_range(0, NREG-1));
      rv = ($urandom_range(0, 99) < 45);
      ra = AW'($urandom_range(0, NREG-1));
      rt = TW'($urandom_range(0, 15));
      cv = ($urandom_range(0, 99) < 60);
      pick = AW'($urandom_range(0, NREG-1));
      ct = (m_pend[pick] && $urandom_range(0, 3) != 0) ? m_tag[pick] : TW'($urandom_range(0, 15));
      step(a0, a1, rv, ra, rt, cv, ct, $urandom, "");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule